// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This unit holds the status word of an SD card host and turns it into one interrupt request line. The command engine, the data engine and the FIFO each send single-cycle event pulses. Each pulse sets its own bit, and that bit stays set until software writes a 1 to its position in the status word. Besides these sticky bits, the status word carries one live bit that follows the FIFO level indication directly. That live bit is never latched.

A configuration word sits next to the status word. It is written in one cycle and read back whole. Four of its bits decide which conditions reach the interrupt line:
- busy done
- block done
- SDIO interrupt
- the live data flag

The five error bits never raise the interrupt. They are gathered into a separate pending-error output, so that the command engine or software can stop a transfer.

Top module: `sd_status_irq`

## Requirements
- R1: After reset the status word, the configuration word, `irq` and `errPending` all read 0.
- R2: A pulse on `eventSet[i]` sets status bit i+3. The bit stays set after the pulse ends. The mapping is: eventSet[0] FIFO error (bit 3), [1] CRC7 error (bit 4), [2] CRC16 error (bit 5), [3] command timeout (bit 6), [4] read/erase/write timeout (bit 7), [5] SDIO interrupt (bit 8), [6] block done (bit 9), [7] busy done (bit 10).
- R3: A status write with `wrStatus` clears each sticky bit whose `wrData` bit is 1. A bit whose `wrData` bit is 0 keeps its value.
- R4: If an event pulse and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 0 equals `dataLive` in the same cycle, with no register in between. Status bits 1 and 2 always read 0.
- R6: A write with `wrCfg` stores all 11 bits of `wrData` into the configuration word, which reads back on `cfgRd`. A status write leaves the configuration word unchanged. A configuration write leaves the status word unchanged.
- R7: `irq` is high whenever any of these pairs is present:
  - busy bit 10 with configuration bit 10;
  - block bit 9 with configuration bit 8;
  - SDIO bit 8 with configuration bit 5.
  No other configuration bit enables these three events.
- R8: The live data flag drives `irq` only while configuration bit 4 is set.
- R9: The error bits (3 to 7) never drive `irq`. `errPending` is high exactly while at least one of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventSet | input | 8 | Event pulses, index i sets status bit i+3 |
| dataLive | input | 1 | Live FIFO level indication (data flag) |
| wrStatus | input | 1 | Status write strobe (write-1-to-clear) |
| wrCfg | input | 1 | Configuration write strobe |
| wrData | input | 11 | Write data for either word |
| statusRd | output | 11 | Status word |
| cfgRd | output | 11 | Configuration word |
| irq | output | 1 | Interrupt request |
| errPending | output | 1 | At least one error bit is set |

## Verification
The bench builds the unit with its default layout: an 11-bit status word whose sticky field starts at bit 3. This places every event position and every enable position at the bit it occupies in use, so each enable can be paired with the wrong event on purpose. The bench also applies several multi-bit set and clear patterns, and a set and a clear to the same bit in the same cycle.

// File: rtl/sd_status_pkg.sv
package sd_status_pkg;
  localparam int unsigned STAT_W    = 11;
  localparam int unsigned STICKY_LO = 3;
  localparam int unsigned N_EV      = STAT_W - STICKY_LO;
  localparam int unsigned ERR_HI    = 7;

  // sticky positions in the status word
  localparam int unsigned B_SDIO  = 8;
  localparam int unsigned B_BLOCK = 9;
  localparam int unsigned B_BUSY  = 10;

  // enable positions in the configuration word
  localparam int unsigned EN_DATA  = 4;
  localparam int unsigned EN_SDIO  = 5;
  localparam int unsigned EN_BLOCK = 8;
  localparam int unsigned EN_BUSY  = 10;

  typedef struct packed {
    logic [N_EV-1:0]   clrMask;
    logic              cfgLoad;
    logic [STAT_W-1:0] cfgValue;
  } ctlStrobes_t;
endpackage

// File: rtl/sd_status_ctl.sv
module sd_status_ctl
  import sd_status_pkg::*;
(
  input  logic              wrStatus,
  input  logic              wrCfg,
  input  logic [STAT_W-1:0] wrData,
  output ctlStrobes_t       strb
);
  // one clear strobe per sticky bit, taken from the write-1 positions
  for (genvar i = 0; i < N_EV; i++) begin : g_clr
    assign strb.clrMask[i] = wrStatus & wrData[i + STICKY_LO];
  end

  assign strb.cfgLoad  = wrCfg;
  assign strb.cfgValue = wrData;
endmodule

// File: rtl/sd_status_dp.sv
module sd_status_dp
  import sd_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [N_EV-1:0]   eventSet,
  input  logic              dataLive,
  output logic [STAT_W-1:0] statusRd,
  output logic [STAT_W-1:0] cfgRd,
  output logic              irq,
  output logic              errPending
);
  localparam int unsigned ERR_N = ERR_HI - STICKY_LO + 1;

  logic [N_EV-1:0]   sticky;
  logic [STAT_W-1:0] cfgQ;

  // set has priority over a same-cycle clear
  for (genvar i = 0; i < N_EV; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN) sticky[i] <= 1'b0;
      else       sticky[i] <= eventSet[i] | (sticky[i] & ~strb.clrMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cfgQ <= '0;
    else if (strb.cfgLoad) cfgQ <= strb.cfgValue;
  end

  assign statusRd   = {sticky, {(STICKY_LO-1){1'b0}}, dataLive};
  assign cfgRd      = cfgQ;
  assign errPending = |sticky[ERR_N-1:0];

  always_comb begin
    irq = 1'b0;
    if (sticky[B_BUSY  - STICKY_LO] && cfgQ[EN_BUSY])  irq = 1'b1;
    if (sticky[B_BLOCK - STICKY_LO] && cfgQ[EN_BLOCK]) irq = 1'b1;
    if (sticky[B_SDIO  - STICKY_LO] && cfgQ[EN_SDIO])  irq = 1'b1;
    if (dataLive && cfgQ[EN_DATA])                     irq = 1'b1;
  end
endmodule

// File: rtl/sd_status_irq.sv
module sd_status_irq
  import sd_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_EV-1:0]   eventSet,
  input  logic              dataLive,
  input  logic              wrStatus,
  input  logic              wrCfg,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] statusRd,
  output logic [STAT_W-1:0] cfgRd,
  output logic              irq,
  output logic              errPending
);
  ctlStrobes_t strb;

  sd_status_ctl u_ctl (
    .wrStatus (wrStatus),
    .wrCfg    (wrCfg),
    .wrData   (wrData),
    .strb     (strb)
  );

  sd_status_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .eventSet   (eventSet),
    .dataLive   (dataLive),
    .statusRd   (statusRd),
    .cfgRd      (cfgRd),
    .irq        (irq),
    .errPending (errPending)
  );
endmodule

// File: rtl/sd_status_irq_chk.sv
module sd_status_irq_chk
  import sd_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [N_EV-1:0]   eventSet,
  input logic              dataLive,
  input logic              wrStatus,
  input logic              wrCfg,
  input logic [STAT_W-1:0] wrData,
  input logic [STAT_W-1:0] statusRd,
  input logic [STAT_W-1:0] cfgRd,
  input logic              irq,
  input logic              errPending
);
  for (genvar i = 0; i < N_EV; i++) begin : g_bit
    // R2 and R4: an event sets its bit even against a clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      eventSet[i] |=> statusRd[i + STICKY_LO]);
    // R2: a set bit holds unless cleared
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      statusRd[i + STICKY_LO] && !(wrStatus && wrData[i + STICKY_LO])
      |=> statusRd[i + STICKY_LO]);
    // R3: write-1 clears when no event competes
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      wrStatus && wrData[i + STICKY_LO] && !eventSet[i]
      |=> !statusRd[i + STICKY_LO]);
  end

  p_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusRd[0] == dataLive && statusRd[2:1] == 2'b00);

  p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCfg |=> cfgRd == $past(wrData));

  p_cfg_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrCfg |=> $stable(cfgRd));

  p_busy_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusRd[B_BUSY] && cfgRd[EN_BUSY] |-> irq);

  p_data_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRd[EN_DATA] && statusRd[B_BUSY:B_SDIO] == 3'b000 |-> !irq);

  p_err_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusRd[ERR_HI:STICKY_LO] == '0 |-> !errPending);

  p_err_noirq_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dataLive && statusRd[B_BUSY:B_SDIO] == 3'b000 |-> !irq);
endmodule

bind sd_status_irq sd_status_irq_chk u_chk (.*);

// File: tb/tb_sd_status_irq.sv
module tb_sd_status_irq;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  eventSet;
  logic        dataLive;
  logic        wrStatus;
  logic        wrCfg;
  logic [10:0] wrData;
  logic [10:0] statusRd;
  logic [10:0] cfgRd;
  logic        irq;
  logic        errPending;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sd_status_irq dut (
    .clk(clk), .rstN(rstN), .eventSet(eventSet), .dataLive(dataLive),
    .wrStatus(wrStatus), .wrCfg(wrCfg), .wrData(wrData),
    .statusRd(statusRd), .cfgRd(cfgRd), .irq(irq), .errPending(errPending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, return at the next falling edge with inputs idle
  task automatic step(input logic [7:0] ev, input logic ws, input logic wc, input logic [10:0] d);
    @(negedge clk);
    eventSet = ev; wrStatus = ws; wrCfg = wc; wrData = d;
    @(negedge clk);
    eventSet = '0; wrStatus = 1'b0; wrCfg = 1'b0; wrData = '0;
  endtask

  task automatic tReset;
    rstN = 1'b0; eventSet = '0; dataLive = 1'b0;
    wrStatus = 1'b0; wrCfg = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    chk("R1 status", statusRd, 0);
    chk("R1 cfg", cfgRd, 0);
    chk("R1 irq", irq, 0);
    chk("R1 errPending", errPending, 0);
    rstN = 1'b1;
  endtask

  task automatic tSetHold;
    step(8'h01, 0, 0, 0);
    chk("R2 set fifo err", statusRd, 11'h008);
    repeat (3) @(negedge clk);
    chk("R2 hold", statusRd, 11'h008);
    chk("R9 errPending", errPending, 1);
    chk("R9 no irq", irq, 0);
  endtask

  task automatic tClear;
    step(8'h00, 1, 0, 11'h000);
    chk("R3 write zero", statusRd, 11'h008);
    step(8'h00, 1, 0, 11'h008);
    chk("R3 clear one", statusRd, 11'h000);
    step(8'hFF, 0, 0, 0);
    chk("R2 set all", statusRd, 11'h7F8);
    step(8'h00, 1, 0, 11'h0A0);
    chk("R3 partial clear", statusRd, 11'h758);
    step(8'h00, 1, 0, 11'h7F8);
    chk("R3 clear all", statusRd, 11'h000);
    chk("R9 errPending low", errPending, 0);
  endtask

  task automatic tSetWins;
    step(8'h80, 1, 0, 11'h400);
    chk("R4 set wins", statusRd, 11'h400);
    step(8'h00, 1, 0, 11'h400);
    chk("R4 then clears", statusRd, 11'h000);
  endtask

  task automatic tCfg;
    step(8'h00, 0, 1, 11'h5A5);
    chk("R6 cfg load", cfgRd, 11'h5A5);
    chk("R6 status unchanged", statusRd, 11'h000);
    step(8'h00, 1, 0, 11'h7FF);
    chk("R6 cfg kept on status write", cfgRd, 11'h5A5);
    step(8'h00, 0, 1, 11'h000);
    chk("R6 cfg zero", cfgRd, 11'h000);
  endtask

  task automatic tLive;
    @(negedge clk);
    dataLive = 1'b1;
    #1;
    chk("R5 live bit", statusRd, 11'h001);
    chk("R8 gated off", irq, 0);
    step(8'h00, 0, 1, 11'h010);
    chk("R8 enabled", irq, 1);
    @(negedge clk);
    dataLive = 1'b0;
    #1;
    chk("R5 live low", statusRd, 11'h000);
    chk("R8 follows live", irq, 0);
    step(8'h00, 0, 1, 11'h000);
  endtask

  task automatic tIrq;
    step(8'h80, 0, 0, 0);
    chk("R7 busy no enable", irq, 0);
    step(8'h00, 0, 1, 11'h400);
    chk("R7 busy enabled", irq, 1);
    step(8'h00, 1, 0, 11'h400);
    chk("R7 busy cleared", irq, 0);
    step(8'h40, 0, 1, 11'h200);
    chk("R7 block wrong enable", irq, 0);
    step(8'h00, 0, 1, 11'h100);
    chk("R7 block enabled", irq, 1);
    step(8'h00, 1, 0, 11'h200);
    chk("R7 block cleared", irq, 0);
    step(8'h20, 0, 0, 0);
    chk("R7 sdio wrong enable", irq, 0);
    step(8'h00, 0, 1, 11'h020);
    chk("R7 sdio enabled", irq, 1);
    step(8'h00, 1, 0, 11'h100);
    chk("R7 sdio cleared", irq, 0);
  endtask

  task automatic tErr;
    step(8'h00, 0, 1, 11'h7FF);
    step(8'h1F, 0, 0, 0);
    chk("R9 errors set", statusRd, 11'h0F8);
    chk("R9 errors no irq", irq, 0);
    chk("R9 errPending", errPending, 1);
    step(8'h00, 1, 0, 11'h040);
    chk("R9 still pending", errPending, 1);
    step(8'h00, 1, 0, 11'h0B8);
    chk("R9 pending cleared", errPending, 0);
  endtask

  initial begin
    tReset;
    tSetHold;
    tClear;
    tSetWins;
    tCfg;
    tLive;
    tIrq;
    tErr;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule